// File: doc/BRIEF.md
# Nine-bit receive address qualifier

This block sits behind the bit sampler of an asynchronous serial receiver. Each time a frame finishes, it decides whether the frame is handed to software. It does so by raising the receive flag and latching the data byte and ninth bit. In the nine-data-bit modes, multiprocessor filtering can be enabled. A frame is then taken only when it is an address frame (ninth bit 1) and its byte fits either the slave's own address pattern or its broadcast pattern. With filtering off, or in the eight-bit modes, every frame is taken.

Two registers define each slave's address patterns: a slave address and an enable mask. Mask bits of 0 turn the matching address bits into don't-care bits. For example, address 1010_0100 with mask 1111_1010 accepts 1010_0x0x. The broadcast pattern is the OR of the two registers: every 1 in it must be matched by a 1 in the byte, and every other position is don't-care. A stop bit sampled low sets a sticky framing-error flag. Bit 7 of the serial control register is shared. A select bit decides whether software reads and writes it as the high mode bit (1 = nine-bit modes) or as the framing-error flag.

Top module: `mpf_top`

## Requirements
- R1: After reset, ri, rx_data, rx_ninth_q, fe and mode_hi are all 0.
- R2: When filtering is off (mode_hi = 0 or mp_en = 0) and ri is 0, a frame_done pulse sets ri and loads rx_data and rx_ninth_q, visible one clock later, whatever the ninth bit.
- R3: With filtering on (mode_hi = 1 and mp_en = 1), a frame with ninth bit 0 never sets ri and leaves rx_data unchanged.
- R4: With filtering on, a frame with ninth bit 1 is taken when every byte bit whose mask bit is 1 equals the matching address bit.
- R5: With filtering on, a frame with ninth bit 1 is taken when the byte has a 1 in every position where (address OR mask) is 1.
- R6: With filtering on, an address frame that fits neither pattern leaves ri at 0 and rx_data unchanged.
- R7: While ri is 1 and ri_clr is not asserted, a new frame changes neither rx_data nor rx_ninth_q.
- R8: ri_clr clears ri one clock later. If a frame that would be taken arrives in the same cycle, the frame wins and ri stays 1 with the new data.
- R9: A frame_done pulse with rx_stop = 0 sets fe one clock later, whether or not the frame is taken.
- R10: fe is cleared only by a control write with fe_sel = 1 and ctl_wbit = 0. Writing 1 has no effect, and a framing error in the same cycle as a clear keeps fe at 1.
- R11: ctl_rbit shows fe when fe_sel = 1 and mode_hi when fe_sel = 0, combinationally. A control write with fe_sel = 0 loads mode_hi from ctl_wbit and does not touch fe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_done | input | 1 | One-cycle pulse: a frame has been fully received |
| rx_byte | input | 8 | Received data byte |
| rx_ninth | input | 1 | Received ninth data bit |
| rx_stop | input | 1 | Sampled stop bit (1 = valid) |
| slave_addr | input | 8 | Slave address register |
| slave_mask | input | 8 | Address enable mask register |
| mp_en | input | 1 | Multiprocessor filtering enable |
| fe_sel | input | 1 | Shared bit 7 select: 1 = framing error, 0 = mode bit |
| ctl_wr | input | 1 | Software write strobe for shared bit 7 |
| ctl_wbit | input | 1 | Value written to shared bit 7 |
| ri_clr | input | 1 | Software clear of the receive flag |
| ri | output | 1 | Receive flag |
| rx_data | output | 8 | Latched data byte of the last frame taken |
| rx_ninth_q | output | 1 | Latched ninth bit of the last frame taken |
| fe | output | 1 | Sticky framing-error flag |
| mode_hi | output | 1 | High mode bit (1 = nine-bit modes) |
| ctl_rbit | output | 1 | Read value of shared bit 7 |

## Verification
A wrong receive-flag state shows on ri one clock after the frame that caused it. It also shows later as a lost frame, because a stuck-high ri blocks every later frame from reaching rx_data. A wrong mode bit shows at once on ctl_rbit when fe_sel is 0, and at the next frame as the wrong filtering decision. A framing-error flag that fails to stick, or clears on the wrong write, shows on fe and on ctl_rbit when fe_sel is 1, in the cycle after the event. The checks use the two given-address examples, a broadcast-only byte, a near-miss byte, overrun, and same-cycle set-versus-clear cases. A long run of random frames and writes is compared against a reference model on every clock.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

    // shared bit 7 of the serial control register and the flag that aliases it
    typedef struct packed {
        logic mode_hi;
        logic fe;
    } mpf_ctl_t;

endpackage

// File: rtl/mpf_match.sv
module mpf_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] rx_byte,
    input  logic [W-1:0] slave_addr,
    input  logic [W-1:0] slave_mask,
    output logic         given_hit,
    output logic         bcast_hit
);

    logic [W-1:0] given_miss;
    logic [W-1:0] bcast_miss;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // a cared-for bit differs from the address
        assign given_miss[i] = slave_mask[i] & (rx_byte[i] ^ slave_addr[i]);
        // broadcast needs a one wherever address or mask holds one
        assign bcast_miss[i] = (slave_addr[i] | slave_mask[i]) & ~rx_byte[i];
    end

    assign given_hit = ~|given_miss;
    assign bcast_hit = ~|bcast_miss;

endmodule

// File: rtl/mpf_ctl.sv
module mpf_ctl
    import mpf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done,
    input  logic rx_stop,
    input  logic fe_sel,
    input  logic ctl_wr,
    input  logic ctl_wbit,
    output logic mode_hi,
    output logic fe,
    output logic ctl_rbit
);

    mpf_ctl_t st_d, st_q;
    logic     bad_stop;
    logic     fe_clear;

    assign bad_stop = frame_done & ~rx_stop;
    assign fe_clear = ctl_wr & fe_sel & ~ctl_wbit;

    always_comb begin
        st_d = st_q;
        if (ctl_wr && !fe_sel) begin
            st_d.mode_hi = ctl_wbit;
        end
        if (bad_stop) begin
            st_d.fe = 1'b1;
        end else if (fe_clear) begin
            st_d.fe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_hi  = st_q.mode_hi;
    assign fe       = st_q.fe;
    assign ctl_rbit = fe_sel ? st_q.fe : st_q.mode_hi;

    // R9
    fe_on_bad_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !rx_stop) |=> fe);

    // R10
    fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fe && !(ctl_wr && fe_sel && !ctl_wbit)) |=> fe);

    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_wr && !fe_sel) |=> $stable(mode_hi));

endmodule

// File: rtl/mpf_rx_gate.sv
module mpf_rx_gate #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_done,
    input  logic [W-1:0] rx_byte,
    input  logic         rx_ninth,
    input  logic         filt_on,
    input  logic         addr_hit,
    input  logic         ri_clr,
    output logic         ri,
    output logic [W-1:0] rx_data,
    output logic         rx_ninth_q
);

    typedef struct packed {
        logic         ri;
        logic [W-1:0] data;
        logic         ninth;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   slot_free;
    logic   qualifies;
    logic   accept;

    assign slot_free = ~st_q.ri | ri_clr;
    assign qualifies = ~filt_on | (rx_ninth & addr_hit);
    assign accept    = frame_done & slot_free & qualifies;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.ri    = 1'b1;
            st_d.data  = rx_byte;
            st_d.ninth = rx_ninth;
        end else if (ri_clr) begin
            st_d.ri = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ri         = st_q.ri;
    assign rx_data    = st_q.data;
    assign rx_ninth_q = st_q.ninth;

    // R2
    ri_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ri) |-> $past(frame_done));

    // R3
    data_frame_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && filt_on && !rx_ninth && !ri) |=> !ri);

    // R4
    hit_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && filt_on && rx_ninth && addr_hit && !ri) |=> ri);

    // R7
    overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ri && !ri_clr) |=> ($stable(rx_data) && $stable(rx_ninth_q) && ri));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ri_clr && !frame_done) |=> !ri);

endmodule

// File: rtl/mpf_top.sv
module mpf_top #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_done,
    input  logic [W-1:0] rx_byte,
    input  logic         rx_ninth,
    input  logic         rx_stop,
    input  logic [W-1:0] slave_addr,
    input  logic [W-1:0] slave_mask,
    input  logic         mp_en,
    input  logic         fe_sel,
    input  logic         ctl_wr,
    input  logic         ctl_wbit,
    input  logic         ri_clr,
    output logic         ri,
    output logic [W-1:0] rx_data,
    output logic         rx_ninth_q,
    output logic         fe,
    output logic         mode_hi,
    output logic         ctl_rbit
);

    logic given_hit;
    logic bcast_hit;
    logic filt_on;

    mpf_match #(.W(W)) u_match (
        .rx_byte    (rx_byte),
        .slave_addr (slave_addr),
        .slave_mask (slave_mask),
        .given_hit  (given_hit),
        .bcast_hit  (bcast_hit)
    );

    mpf_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .rx_stop    (rx_stop),
        .fe_sel     (fe_sel),
        .ctl_wr     (ctl_wr),
        .ctl_wbit   (ctl_wbit),
        .mode_hi    (mode_hi),
        .fe         (fe),
        .ctl_rbit   (ctl_rbit)
    );

    assign filt_on = mode_hi & mp_en;

    mpf_rx_gate #(.W(W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .rx_byte    (rx_byte),
        .rx_ninth   (rx_ninth),
        .filt_on    (filt_on),
        .addr_hit   (given_hit | bcast_hit),
        .ri_clr     (ri_clr),
        .ri         (ri),
        .rx_data    (rx_data),
        .rx_ninth_q (rx_ninth_q)
    );

    // R6
    miss_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && filt_on && !given_hit && !bcast_hit && !ri && !ri_clr)
        |=> (!ri && $stable(rx_data)));

endmodule

// File: tb/mpf_top_test.sv
`timescale 1ns/1ps
module mpf_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_done = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_ninth = 1'b0;
    logic       rx_stop = 1'b1;
    logic [7:0] slave_addr = 8'h00;
    logic [7:0] slave_mask = 8'h00;
    logic       mp_en = 1'b0;
    logic       fe_sel = 1'b0;
    logic       ctl_wr = 1'b0;
    logic       ctl_wbit = 1'b0;
    logic       ri_clr = 1'b0;
    logic       ri;
    logic [7:0] rx_data;
    logic       rx_ninth_q;
    logic       fe;
    logic       mode_hi;
    logic       ctl_rbit;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    // reference model state
    bit       m_ri, m_ninth, m_fe, m_mode;
    bit [7:0] m_data;

    always #2.5 clk = ~clk;

    mpf_top uut (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .rx_byte(rx_byte),
        .rx_ninth(rx_ninth), .rx_stop(rx_stop), .slave_addr(slave_addr),
        .slave_mask(slave_mask), .mp_en(mp_en), .fe_sel(fe_sel), .ctl_wr(ctl_wr),
        .ctl_wbit(ctl_wbit), .ri_clr(ri_clr), .ri(ri), .rx_data(rx_data),
        .rx_ninth_q(rx_ninth_q), .fe(fe), .mode_hi(mode_hi), .ctl_rbit(ctl_rbit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit fits(input bit [7:0] b, input bit [7:0] a, input bit [7:0] m);
        bit ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (m[i] && (b[i] != a[i])) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic bit fits_bcast(input bit [7:0] b, input bit [7:0] a, input bit [7:0] m);
        bit ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if ((a[i] || m[i]) && !b[i]) ok = 1'b0;
        end
        return ok;
    endfunction

    // behavioural model, advanced at each rising edge from the held inputs
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ri = 0; m_ninth = 0; m_fe = 0; m_mode = 0; m_data = 0;
        end else begin
            bit take;
            bit n_mode;
            take = frame_done;
            if (m_ri && !ri_clr) take = 0;
            if (m_mode && mp_en) begin
                if (!rx_ninth) take = 0;
                else if (!fits(rx_byte, slave_addr, slave_mask) &&
                         !fits_bcast(rx_byte, slave_addr, slave_mask)) take = 0;
            end
            n_mode = m_mode;
            if (ctl_wr && !fe_sel) n_mode = ctl_wbit;
            if (frame_done && !rx_stop) m_fe = 1;
            else if (ctl_wr && fe_sel && !ctl_wbit) m_fe = 0;
            if (take) begin
                m_ri = 1; m_data = rx_byte; m_ninth = rx_ninth;
            end else if (ri_clr) begin
                m_ri = 0;
            end
            m_mode = n_mode;
        end
    end

    // per-clock comparison of registered outputs
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2 model ri", ri, m_ri);
            check("R7 model rx_data", rx_data, m_data);
            check("R7 model ninth", rx_ninth_q, m_ninth);
            check("R9 model fe", fe, m_fe);
            check("R11 model mode_hi", mode_hi, m_mode);
        end
    end

    // one cycle of stimulus, launched at a falling edge
    task automatic cyc(input bit fd, input bit [7:0] b, input bit n9, input bit stp,
                       input bit clr, input bit wr, input bit sel, input bit wb);
        @(negedge clk);
        frame_done = fd; rx_byte = b; rx_ninth = n9; rx_stop = stp;
        ri_clr = clr; ctl_wr = wr; fe_sel = sel; ctl_wbit = wb;
        @(negedge clk);
        frame_done = 0; ri_clr = 0; ctl_wr = 0; rx_stop = 1;
        #1;
    endtask

    task automatic frame(input bit [7:0] b, input bit n9);
        cyc(1, b, n9, 1, 0, 0, fe_sel, 0);
    endtask

    task automatic clear_ri();
        cyc(0, 8'h00, 0, 1, 1, 0, fe_sel, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #1;
        // R1: reset state
        check("R1 ri", ri, 0);
        check("R1 rx_data", rx_data, 0);
        check("R1 ninth", rx_ninth_q, 0);
        check("R1 fe", fe, 0);
        check("R1 mode_hi", mode_hi, 0);
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R2: eight-bit mode takes any frame
        frame(8'h3C, 0);
        check("R2 ri", ri, 1);
        check("R2 rx_data", rx_data, 8'h3C);
        clear_ri();
        check("R8 clear", ri, 0);

        // R11: load mode bit through the shared position
        cyc(0, 8'h00, 0, 1, 0, 1, 0, 1);
        check("R11 mode_hi", mode_hi, 1);
        check("R11 rbit mode", ctl_rbit, 1);
        mp_en = 1; slave_addr = 8'hA4; slave_mask = 8'hFA;

        // R3: data frame under filtering
        frame(8'hA4, 0);
        check("R3 ri", ri, 0);
        check("R3 rx_data", rx_data, 8'h3C);

        // R4: 1010_0x0x accepts A5
        frame(8'hA5, 1);
        check("R4 ri", ri, 1);
        check("R4 rx_data", rx_data, 8'hA5);
        check("R4 ninth", rx_ninth_q, 1);
        clear_ri();

        // R6: A6 fits neither pattern (broadcast FE)
        frame(8'hA6, 1);
        check("R6 ri", ri, 0);
        check("R6 rx_data", rx_data, 8'hA5);

        // R5: FE only fits broadcast
        frame(8'hFE, 1);
        check("R5 ri", ri, 1);
        check("R5 rx_data", rx_data, 8'hFE);
        clear_ri();

        // R4: 1010_0xx1 accepts A1
        slave_addr = 8'hA7; slave_mask = 8'hF9;
        frame(8'hA1, 1);
        check("R4 second ri", ri, 1);
        check("R4 second data", rx_data, 8'hA1);
        clear_ri();

        // R7: overrun keeps first byte
        frame(8'hA5, 1);
        check("R7 first", rx_data, 8'hA5);
        frame(8'hA7, 1);
        check("R7 ri", ri, 1);
        check("R7 rx_data", rx_data, 8'hA5);

        // R8: clear and accepted frame in one cycle
        cyc(1, 8'hA1, 1, 1, 1, 0, 0, 0);
        check("R8 ri", ri, 1);
        check("R8 rx_data", rx_data, 8'hA1);

        // R9: bad stop on an ignored frame
        cyc(1, 8'h00, 0, 0, 0, 0, 0, 0);
        check("R9 fe", fe, 1);
        check("R9 rx_data", rx_data, 8'hA1);
        fe_sel = 1; #1;
        check("R11 rbit fe", ctl_rbit, 1);

        // R10: writing 1 does not clear
        cyc(0, 8'h00, 0, 1, 0, 1, 1, 1);
        check("R10 write one", fe, 1);
        // R11: mode write leaves fe alone
        cyc(0, 8'h00, 0, 1, 0, 1, 0, 1);
        check("R11 fe kept", fe, 1);
        check("R11 mode kept", mode_hi, 1);
        // R10: write 0 clears
        cyc(0, 8'h00, 0, 1, 0, 1, 1, 0);
        check("R10 cleared", fe, 0);
        check("R11 rbit cleared", ctl_rbit, 0);
        // R10: set beats clear
        cyc(1, 8'h00, 0, 0, 0, 1, 1, 0);
        check("R10 set wins", fe, 1);
        cyc(0, 8'h00, 0, 1, 0, 1, 1, 0);

        // R2: filtering disabled in nine-bit mode
        mp_en = 0;
        clear_ri();
        frame(8'h11, 0);
        check("R2 mp off ri", ri, 1);
        check("R2 mp off data", rx_data, 8'h11);

        // random phase against the model
        for (int k = 0; k < 600; k++) begin
            slave_addr = 8'($urandom); slave_mask = 8'($urandom);
            mp_en = 1'($urandom);
            cyc(($urandom % 3) != 0, 8'($urandom), 1'($urandom), ($urandom % 4) != 0,
                ($urandom % 4) == 0, ($urandom % 8) == 0, 1'($urandom), 1'($urandom));
        end

        @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule